// File: doc/BRIEF.md
# Operand Forwarding and Stall Controller

This block is pure combinational logic for the decode stage of a five-stage in-order pipeline with a 32-entry register file. It looks at the instruction in decode: its opcode and its two source register indices. It also looks at the two older instructions still in flight: the EXE/MEM entry (destination index, register-write flag, load flag) and the MEM/WB entry (destination index, register-write flag). From these it picks where each ALU operand comes from. It also decides whether the store-data path must take the EXE/MEM result, and whether the front of the pipeline must freeze for one cycle.

Decoding is limited to sorting opcodes by how they use their sources. Opcode values (4 significant bits, zero-extended to the opcode width) are:

| Opcode | Value |
|---|---|
| add | 0 |
| sub | 1 |
| and | 2 |
| or | 3 |
| sll | 4 |
| srl | 5 |
| sra | 6 |
| add-immediate | 7 |
| load | 8 |
| store | 9 |
| beq | 10 |
| bne | 11 |
| unconditional jump | 12 |

Values 13 to 15 are treated as immediate-form ALU operations.

When a stall is raised, the surrounding pipeline holds the program counter and the fetch register, and it inserts a bubble into the execute stage.

Top module: `fwd_hazard_unit`

## Requirements
- R1: Source A is a register operand for every opcode except beq (10), bne (11) and jump (12). For those three, `alu_a_sel` is 0 and source A never causes a load stall.
- R2: Source B is a register operand only for add, sub, and, or, sll, srl and sra (0 to 6). For any other opcode, `alu_b_sel` is 1, which selects the immediate.
- R3: Operand select code 0 means the register file, 2 means the EXE/MEM result and 3 means the MEM/WB result. `alu_a_sel` never takes the value 1.
- R4: A stage can be the forwarding source for an operand only when its register-write flag is 1 and its destination index equals that operand's source index.
- R5: When both EXE/MEM and MEM/WB match the same register operand, the select is 2, so the younger result wins.
- R6: `load_stall` is 1 when the EXE/MEM load flag is 1 and its destination equals source A (if A is a register operand) or source B (if B is a register operand).
- R7: `load_stall` is also 1 when the decode opcode is store (9) and source B equals the destination of a load in EXE/MEM.
- R8: `store_fwd` is 1 exactly when source B equals the EXE/MEM destination and the EXE/MEM register-write flag is 1.
- R9: For beq and bne, the unit stalls when EXE/MEM has its register-write flag at 1 and its load flag at 0.
- R10: While stalled, `pc_we` and `fetch_we` are 0 and `inject_bubble` is 1. Otherwise `pc_we` and `fetch_we` are 1 and `inject_bubble` is 0.
- R11: Register index 0 never matches. A write to it forwards nothing and causes no load stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_opcode | input | 6 | Opcode of the instruction in decode |
| dec_src_a | input | 5 | Source A register index |
| dec_src_b | input | 5 | Source B register index (data register for stores) |
| em_dst | input | 5 | EXE/MEM destination index |
| em_wr | input | 1 | EXE/MEM register-write flag |
| em_load | input | 1 | EXE/MEM instruction is a load |
| mw_dst | input | 5 | MEM/WB destination index |
| mw_wr | input | 1 | MEM/WB register-write flag |
| alu_a_sel | output | 2 | ALU A operand source code |
| alu_b_sel | output | 2 | ALU B operand source code |
| store_fwd | output | 1 | Store data taken from the EXE/MEM result |
| load_stall | output | 1 | Load-use hazard detected |
| pc_we | output | 1 | Program counter write enable |
| fetch_we | output | 1 | Fetch register write enable |
| inject_bubble | output | 1 | Clear all write flags entering execute |

## Verification
The bench targets these corner cases:

- **Double match.** Both older stages match the same source. A design with the priority reversed would feed the stale MEM/WB value.
- **Index zero.** Writes target register 0. A design that drops the zero guard would forward garbage or stall for no reason.
- **Load followed by store.** The store reads its data register. Missing the store case would write a value that does not yet exist.
- **Branch after ALU op.** A branch follows an ALU instruction. A design that does not hold the branch would compare stale operands.
- **Branch and jump sources.** Source A of a branch or jump matches a loaded register. A design that does not suppress A here would stall for no reason.

Random vectors over a narrow index range keep matches frequent.

// File: rtl/fwd_hazard_pkg.sv
package fwd_hazard_pkg;
   // Operand source codes
   localparam logic [1:0] SEL_RF  = 2'd0;
   localparam logic [1:0] SEL_IMM = 2'd1;
   localparam logic [1:0] SEL_EM  = 2'd2;
   localparam logic [1:0] SEL_MW  = 2'd3;

   // Opcode values (zero-extended to the opcode width)
   localparam int unsigned OPC_ADD   = 0;
   localparam int unsigned OPC_SUB   = 1;
   localparam int unsigned OPC_AND   = 2;
   localparam int unsigned OPC_OR    = 3;
   localparam int unsigned OPC_SLL   = 4;
   localparam int unsigned OPC_SRL   = 5;
   localparam int unsigned OPC_SRA   = 6;
   localparam int unsigned OPC_ADDI  = 7;
   localparam int unsigned OPC_LOAD  = 8;
   localparam int unsigned OPC_STORE = 9;
   localparam int unsigned OPC_BEQ   = 10;
   localparam int unsigned OPC_BNE   = 11;
   localparam int unsigned OPC_JUMP  = 12;

   typedef struct packed {
      logic a_is_reg;
      logic b_is_reg;
      logic is_store;
      logic is_cbranch;
   } src_class_t;
endpackage

// File: rtl/hz_src_decode.sv
module hz_src_decode
   import fwd_hazard_pkg::*;
#(
   parameter int unsigned OPC_W = 6
) (
   input  logic [OPC_W-1:0] opcode,
   output src_class_t       cls
);
   localparam int unsigned OPV_W = (OPC_W > 32) ? 32 : OPC_W;

   logic [31:0] opv;

   initial begin
      if (OPC_W < 4) $error("hz_src_decode: OPC_W must be at least 4");
   end

   always_comb begin
      opv            = 32'(opcode[OPV_W-1:0]);
      cls.is_cbranch = (opv == OPC_BEQ) || (opv == OPC_BNE);
      cls.a_is_reg   = !(cls.is_cbranch || (opv == OPC_JUMP));
      cls.b_is_reg   = (opv <= OPC_SRA);
      cls.is_store   = (opv == OPC_STORE);
   end
endmodule

// File: rtl/hz_idx_match.sv
module hz_idx_match #(
   parameter int unsigned IDX_W     = 5,
   parameter bit          SKIP_ZERO = 1'b1
) (
   input  logic [IDX_W-1:0] src,
   input  logic [IDX_W-1:0] dst,
   input  logic             flag,
   output logic             hit
);
   generate
      if (SKIP_ZERO) begin : g_zero_guard
         assign hit = flag && (src == dst) && (dst != '0);
      end else begin : g_plain
         assign hit = flag && (src == dst);
      end
   endgenerate
endmodule

// File: rtl/hz_opnd_sel.sv
module hz_opnd_sel
   import fwd_hazard_pkg::*;
#(
   parameter bit HAS_IMM = 1'b0
) (
   input  logic       is_reg,
   input  logic       hit_em,
   input  logic       hit_mw,
   output logic [1:0] sel
);
   logic [1:0] non_reg_code;

   generate
      if (HAS_IMM) begin : g_imm
         assign non_reg_code = SEL_IMM;
      end else begin : g_rf
         assign non_reg_code = SEL_RF;
      end
   endgenerate

   always_comb begin
      if (!is_reg)     sel = non_reg_code;
      else if (hit_em) sel = SEL_EM;   // younger result has priority
      else if (hit_mw) sel = SEL_MW;
      else             sel = SEL_RF;
   end
endmodule

// File: rtl/hz_stall_ctl.sv
module hz_stall_ctl (
   input  logic load_hit,
   input  logic is_cbranch,
   input  logic em_wr,
   input  logic em_load,
   output logic load_stall,
   output logic pc_we,
   output logic fetch_we,
   output logic inject_bubble
);
   logic branch_hold;
   logic hold;

   always_comb begin
      branch_hold   = is_cbranch && em_wr && !em_load;
      load_stall    = load_hit;
      hold          = load_hit || branch_hold;
      pc_we         = !hold;
      fetch_we      = !hold;
      inject_bubble = hold;
   end
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
   import fwd_hazard_pkg::*;
#(
   parameter int unsigned NUM_REGS  = 32,
   parameter int unsigned OPC_W     = 6,
   parameter bit          SKIP_ZERO = 1'b1,
   localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
   input  logic [OPC_W-1:0] dec_opcode,
   input  logic [IDX_W-1:0] dec_src_a,
   input  logic [IDX_W-1:0] dec_src_b,
   input  logic [IDX_W-1:0] em_dst,
   input  logic             em_wr,
   input  logic             em_load,
   input  logic [IDX_W-1:0] mw_dst,
   input  logic             mw_wr,
   output logic [1:0]       alu_a_sel,
   output logic [1:0]       alu_b_sel,
   output logic             store_fwd,
   output logic             load_stall,
   output logic             pc_we,
   output logic             fetch_we,
   output logic             inject_bubble
);
   localparam int unsigned NUM_SRC = 2;

   initial begin
      if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0)
         $error("fwd_hazard_unit: NUM_REGS must be a power of two >= 2");
   end

   src_class_t cls;

   logic [IDX_W-1:0] src    [NUM_SRC];
   logic             is_reg [NUM_SRC];
   logic             hit_em [NUM_SRC];
   logic             hit_mw [NUM_SRC];
   logic             hit_ld [NUM_SRC];
   logic [1:0]       sel    [NUM_SRC];
   logic             load_hit;

   hz_src_decode #(.OPC_W(OPC_W)) u_dec (
      .opcode (dec_opcode),
      .cls    (cls)
   );

   assign src[0]    = dec_src_a;
   assign src[1]    = dec_src_b;
   assign is_reg[0] = cls.a_is_reg;
   assign is_reg[1] = cls.b_is_reg;

   generate
      for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
         hz_idx_match #(.IDX_W(IDX_W), .SKIP_ZERO(SKIP_ZERO)) u_em (
            .src(src[k]), .dst(em_dst), .flag(em_wr), .hit(hit_em[k]));
         hz_idx_match #(.IDX_W(IDX_W), .SKIP_ZERO(SKIP_ZERO)) u_mw (
            .src(src[k]), .dst(mw_dst), .flag(mw_wr), .hit(hit_mw[k]));
         hz_idx_match #(.IDX_W(IDX_W), .SKIP_ZERO(SKIP_ZERO)) u_ld (
            .src(src[k]), .dst(em_dst), .flag(em_load), .hit(hit_ld[k]));
         hz_opnd_sel #(.HAS_IMM(k == 1)) u_sel (
            .is_reg (is_reg[k]),
            .hit_em (hit_em[k]),
            .hit_mw (hit_mw[k]),
            .sel    (sel[k])
         );
      end
   endgenerate

   assign load_hit  = (hit_ld[0] && is_reg[0]) ||
                      (hit_ld[1] && (is_reg[1] || cls.is_store));
   assign alu_a_sel = sel[0];
   assign alu_b_sel = sel[1];
   assign store_fwd = hit_em[1];

   hz_stall_ctl u_stall (
      .load_hit      (load_hit),
      .is_cbranch    (cls.is_cbranch),
      .em_wr         (em_wr),
      .em_load       (em_load),
      .load_stall    (load_stall),
      .pc_we         (pc_we),
      .fetch_we      (fetch_we),
      .inject_bubble (inject_bubble)
   );
endmodule

// File: rtl/fwd_hazard_unit_chk.sv
module fwd_hazard_unit_chk #(
   parameter int unsigned IDX_W = 5,
   parameter int unsigned OPC_W = 6
) (
   input logic [OPC_W-1:0] dec_opcode,
   input logic [IDX_W-1:0] dec_src_a,
   input logic [IDX_W-1:0] dec_src_b,
   input logic [IDX_W-1:0] em_dst,
   input logic             em_wr,
   input logic             em_load,
   input logic [IDX_W-1:0] mw_dst,
   input logic             mw_wr,
   input logic [1:0]       alu_a_sel,
   input logic [1:0]       alu_b_sel,
   input logic             store_fwd,
   input logic             load_stall,
   input logic             pc_we,
   input logic             fetch_we,
   input logic             inject_bubble
);
   always_comb begin
      a_r3_a_no_imm: assert (alu_a_sel != 2'd1);
      a_r4_em_needs_write: assert (!(alu_a_sel == 2'd2 || alu_b_sel == 2'd2) || em_wr);
      a_r4_mw_needs_write: assert (!(alu_a_sel == 2'd3 || alu_b_sel == 2'd3) || mw_wr);
      a_r8_store_fwd_write: assert (!store_fwd || (em_wr && dec_src_b == em_dst));
      a_r6_stall_needs_load: assert (!load_stall || em_load);
      a_r10_hold_consistent: assert ((pc_we == fetch_we) && (pc_we != inject_bubble));
      a_r10_stall_freezes: assert (!load_stall || !pc_we);
      a_r11_zero_no_fwd: assert (!store_fwd || em_dst != '0);
   end
endmodule

bind fwd_hazard_unit fwd_hazard_unit_chk #(.IDX_W(IDX_W), .OPC_W(OPC_W)) u_chk (.*);

// File: tb/fwd_hazard_unit_test.sv
module fwd_hazard_unit_test;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [5:0] op;
   logic [4:0] sa, sb, ed, md;
   logic       ew, el, mwr;
   logic [1:0] asel, bsel;
   logic       sfwd, lst, pcw, fw, bub;

   int n_vec = 0;
   int n_bad = 0;

   fwd_hazard_unit uut (
      .dec_opcode(op), .dec_src_a(sa), .dec_src_b(sb),
      .em_dst(ed), .em_wr(ew), .em_load(el), .mw_dst(md), .mw_wr(mwr),
      .alu_a_sel(asel), .alu_b_sel(bsel), .store_fwd(sfwd), .load_stall(lst),
      .pc_we(pcw), .fetch_we(fw), .inject_bubble(bub));

   function automatic bit a_reg(input logic [5:0] o);
      return !(o == 10 || o == 11 || o == 12);
   endfunction
   function automatic bit b_reg(input logic [5:0] o);
      return o <= 6;
   endfunction
   function automatic bit hit(input logic [4:0] s, input logic [4:0] d, input logic f);
      return f && s == d && d != 0;
   endfunction
   function automatic logic [1:0] exp_sel(input bit isr, input bit imm,
                                          input bit he, input bit hm);
      if (!isr) return imm ? 2'd1 : 2'd0;
      if (he) return 2'd2;
      if (hm) return 2'd3;
      return 2'd0;
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [5:0] o, input logic [4:0] a, input logic [4:0] b,
                        input logic [4:0] e, input logic w, input logic l,
                        input logic [4:0] m, input logic mw_i, input string tag);
      bit ldh, br, hold;
      @(posedge clk);
      op = o; sa = a; sb = b; ed = e; ew = w; el = l; md = m; mwr = mw_i;
      @(negedge clk);
      ldh  = (hit(a, e, l) && a_reg(o)) || (hit(b, e, l) && (b_reg(o) || o == 9));
      br   = (o == 10 || o == 11) && w && !l;
      hold = ldh || br;
      chk({tag, " R1/R3/R4/R5"}, "alu_a_sel", asel,
          exp_sel(a_reg(o), 1'b0, hit(a, e, w), hit(a, m, mw_i)));
      chk({tag, " R2/R3/R4/R5"}, "alu_b_sel", bsel,
          exp_sel(b_reg(o), 1'b1, hit(b, e, w), hit(b, m, mw_i)));
      chk({tag, " R8/R11"}, "store_fwd", sfwd, hit(b, e, w));
      chk({tag, " R6/R7"}, "load_stall", lst, ldh);
      chk({tag, " R9/R10"}, "pc_we", pcw, !hold);
      chk({tag, " R10"}, "fetch_we", fw, !hold);
      chk({tag, " R10"}, "inject_bubble", bub, hold);
   endtask

   initial begin
      #400000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      op = 0; sa = 0; sb = 0; ed = 0; ew = 0; el = 0; md = 0; mwr = 0;
      // idle state: no hazards
      apply(0, 0, 0, 0, 0, 0, 0, 0, "reset R10");
      // R4/R5: back-to-back ALU dependences, both stages match
      apply(0, 3, 4, 3, 1, 0, 3, 1, "R5 double A");
      apply(1, 5, 6, 6, 1, 0, 6, 1, "R5 double B");
      apply(2, 7, 8, 9, 1, 0, 7, 1, "R4 mw only");
      apply(3, 7, 8, 7, 0, 0, 9, 1, "R4 no write");
      // R2 immediate form
      apply(7, 4, 4, 4, 1, 0, 4, 1, "R2 addi");
      // R6 load-use
      apply(0, 5, 9, 5, 1, 1, 0, 0, "R6 loaduse A");
      apply(8, 1, 5, 5, 1, 1, 0, 0, "R6 load B imm");
      // R7 load -> store
      apply(9, 2, 5, 5, 1, 1, 0, 0, "R7 store data");
      // R1 branch A suppressed
      apply(10, 5, 1, 5, 1, 1, 0, 0, "R1 beq load");
      apply(12, 5, 6, 5, 1, 1, 5, 1, "R1 jump");
      // R9 branch after ALU
      apply(11, 3, 3, 3, 1, 0, 0, 0, "R9 bne alu");
      apply(10, 3, 3, 3, 0, 0, 3, 1, "R9 beq nowr");
      // R11 index zero
      apply(0, 0, 0, 0, 1, 1, 0, 1, "R11 zero");
      apply(9, 0, 0, 0, 1, 1, 0, 1, "R11 zero st");
      for (int i = 0; i < 3000; i++) begin
         apply(6'($urandom_range(0, 15)), 5'($urandom_range(0, 3)),
               5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               5'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), "rand");
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule